// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control around a successive-approximation converter. It counts half periods of the converter clock, so that the points that fall on a half cycle are exact. It launches conversions from a software start bit or from an external trigger, and it raises a one-half-cycle sample-and-hold strobe at the point that suits the conversion type. When the conversion completes it sets a sticky completion flag and captures the converter's output word.

Software writes a channel and a reference code into a holding register. The active selection that feeds the analog multiplexer copies from that holding register whenever it is safe to do so. It is frozen from the start of a conversion, and it opens again at the start of the final converter clock cycle. The first conversion after the block is enabled takes longer than later ones. Clearing the enable aborts any conversion in progress and makes the next one a first conversion again.

The converted word leaves through a valid/ready port. On completion the word is captured and `res_valid` rises. `res_valid` and `res_data` hold steady until a cycle with `res_ready` high accepts the word. Back-pressure never stalls the converter: a completion that arrives while a word is still waiting replaces it, so the newest result wins.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, busy, start bit, completion flag, irq, sample strobe and res_valid are all 0, and the active channel and reference are 0.
- R2: While no conversion holds the lock, a holding-register write reaches the active channel/reference outputs on the second clock edge after the write.
- R3: From the launch edge, the active selection is frozen and ignores holding-register writes. It takes the latest holding value on edge LEN-1 counted from launch, one half-tick before the completion flag sets on edge LEN.
- R4: In single mode, a start write is taken on one edge. The conversion then launches at the next rising converter edge. A rising edge is a half_tick at which the internal phase (reset 0, toggled on every half_tick) is 0. Launch is therefore 1 or 2 half-ticks after the write, never on the same edge.
- R5: The first conversion after reset or after en returns high lasts 50 half-ticks, with the sample strobe 27 half-ticks after launch.
- R6: Later single-mode conversions last 26 half-ticks, with the sample strobe 3 half-ticks after launch.
- R7: In auto mode, a trigger on a half_tick launches a conversion on that same edge. It lasts 27 half-ticks, with the strobe 4 half-ticks after launch. A trigger that arrives while busy is ignored.
- R8: At completion the start bit clears in single mode. In auto mode it stays set.
- R9: The completion flag stays set until a clear write, and irq is high exactly when the flag and irq_en are both high.
- R10: With en low, a conversion in progress is aborted (busy 0, start bit 0) on the next edge. The next conversion is then a first conversion.
- R11: res_data takes adc_word at completion, and res_valid then stays high with stable data until res_ready is seen. A new completion overwrites a word that has not been accepted.
- R12: The sample strobe is high for exactly one half-tick per conversion, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | Enable marking one half period of the converter clock |
| en | input | 1 | Converter enable; low aborts and rearms the first-conversion timing |
| auto_mode | input | 1 | 1: trigger-launched conversions; 0: single conversions from the start bit |
| start_wr | input | 1 | Pulse that sets the start bit |
| trig | input | 1 | External trigger event, used in auto mode |
| sel_wr | input | 1 | Write strobe for the holding register |
| sel_ch_in | input | CH_W | Channel code to hold |
| sel_ref_in | input | REF_W | Reference code to hold |
| flag_clr | input | 1 | Pulse that clears the completion flag |
| irq_en | input | 1 | Interrupt enable |
| adc_word | input | RES_W | Converter output word, captured at completion |
| res_ready | input | 1 | Result consumer ready |
| start_bit | output | 1 | Start bit status |
| busy | output | 1 | Conversion in progress |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt request |
| act_ch | output | CH_W | Active channel selection |
| act_ref | output | REF_W | Active reference selection |
| res_valid | output | 1 | Result word waiting |
| res_data | output | RES_W | Result word |

## Verification
The properties assume that `rst_n` is the only asynchronous input. They also assume that the completion flag is cleared only through the dedicated clear pulse and that `res_ready` is sampled on the same edge as the data. The bench keeps `half_tick` high, so that every clock is one half period. It changes every input on the falling clock edge and holds each command pulse for exactly one clock. Triggers are pulsed only on chosen half-ticks, and the flag is cleared between conversions except where stickiness and overwrite are under test.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int FIRST_HALVES = 50;
  localparam int NORM_HALVES  = 26;
  localparam int AUTO_HALVES  = 27;
  localparam int FIRST_SH     = 27;
  localparam int NORM_SH      = 3;
  localparam int AUTO_SH      = 4;
  localparam int CNT_W        = $clog2(FIRST_HALVES + 1);

  typedef logic [CNT_W-1:0] hcnt_t;

  typedef enum logic [1:0] {
    CONV_FIRST = 2'd0,
    CONV_NORM  = 2'd1,
    CONV_AUTO  = 2'd2
  } conv_kind_e;

  function automatic hcnt_t kind_len(input conv_kind_e k);
    case (k)
      CONV_FIRST: return hcnt_t'(FIRST_HALVES);
      CONV_AUTO:  return hcnt_t'(AUTO_HALVES);
      default:    return hcnt_t'(NORM_HALVES);
    endcase
  endfunction

  function automatic hcnt_t kind_sh(input conv_kind_e k);
    case (k)
      CONV_FIRST: return hcnt_t'(FIRST_SH);
      CONV_AUTO:  return hcnt_t'(AUTO_SH);
      default:    return hcnt_t'(NORM_SH);
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  input  logic en,
  input  logic auto_mode,
  input  logic start_wr,
  input  logic trig,
  input  logic flag_clr,
  output logic busy,
  output logic start_bit,
  output logic done_flag,
  output logic sh_strobe,
  output logic locked,
  output logic done_evt
);

  logic       phase;
  logic       first_pend;
  hcnt_t      hc;
  conv_kind_e kind;
  hcnt_t      len_cur;
  hcnt_t      sh_cur;
  logic       launch;

  always_comb begin
    len_cur   = kind_len(kind);
    sh_cur    = kind_sh(kind);
    launch    = en && half_tick && !busy &&
                (auto_mode ? trig : (start_bit && !phase));
    done_evt  = en && half_tick && busy && (hc == len_cur - hcnt_t'(1));
    locked    = busy && (hc < len_cur - hcnt_t'(2));
    sh_strobe = busy && (hc == sh_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      first_pend <= 1'b1;
      busy       <= 1'b0;
      start_bit  <= 1'b0;
      done_flag  <= 1'b0;
      hc         <= '0;
      kind       <= CONV_FIRST;
    end else begin
      if (half_tick) phase <= ~phase;
      if (flag_clr)  done_flag <= 1'b0;
      if (done_evt)  done_flag <= 1'b1;
      if (!en) begin
        busy       <= 1'b0;
        start_bit  <= 1'b0;
        first_pend <= 1'b1;
        hc         <= '0;
      end else begin
        if (start_wr) start_bit <= 1'b1;
        if (done_evt) begin
          busy <= 1'b0;
          if (!auto_mode) start_bit <= 1'b0;
        end else if (busy && half_tick) begin
          hc <= hc + hcnt_t'(1);
        end else if (launch) begin
          busy       <= 1'b1;
          hc         <= '0;
          first_pend <= 1'b0;
          kind       <= first_pend ? CONV_FIRST : (auto_mode ? CONV_AUTO : CONV_NORM);
          if (auto_mode) start_bit <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
  parameter int CH_W  = 5,
  parameter int REF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [CH_W-1:0]  ch_in,
  input  logic [REF_W-1:0] ref_in,
  input  logic             locked,
  output logic [CH_W-1:0]  act_ch,
  output logic [REF_W-1:0] act_ref
);

  logic [CH_W-1:0]  hold_ch;
  logic [REF_W-1:0] hold_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ch  <= '0;
      hold_ref <= '0;
      act_ch   <= '0;
      act_ref  <= '0;
    end else begin
      if (sel_wr) begin
        hold_ch  <= ch_in;
        hold_ref <= ref_in;
      end
      if (!locked) begin
        act_ch  <= hold_ch;
        act_ref <= hold_ref;
      end
    end
  end

endmodule

// File: rtl/adc_res_port.sv
module adc_res_port #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [RES_W-1:0] din,
  input  logic             ready,
  output logic             valid,
  output logic [RES_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (cap) begin
      valid <= 1'b1;
      data  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CH_W  = 5,
  parameter int REF_W = 2,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             en,
  input  logic             auto_mode,
  input  logic             start_wr,
  input  logic             trig,
  input  logic             sel_wr,
  input  logic [CH_W-1:0]  sel_ch_in,
  input  logic [REF_W-1:0] sel_ref_in,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic [RES_W-1:0] adc_word,
  input  logic             res_ready,
  output logic             start_bit,
  output logic             busy,
  output logic             sh_strobe,
  output logic             done_flag,
  output logic             irq,
  output logic [CH_W-1:0]  act_ch,
  output logic [REF_W-1:0] act_ref,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);

  logic locked;
  logic done_evt;

  adc_seq_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .en        (en),
    .auto_mode (auto_mode),
    .start_wr  (start_wr),
    .trig      (trig),
    .flag_clr  (flag_clr),
    .busy      (busy),
    .start_bit (start_bit),
    .done_flag (done_flag),
    .sh_strobe (sh_strobe),
    .locked    (locked),
    .done_evt  (done_evt)
  );

  adc_sel_shadow #(.CH_W(CH_W), .REF_W(REF_W)) shadow_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_wr  (sel_wr),
    .ch_in   (sel_ch_in),
    .ref_in  (sel_ref_in),
    .locked  (locked),
    .act_ch  (act_ch),
    .act_ref (act_ref)
  );

  adc_res_port #(.RES_W(RES_W)) res_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (done_evt),
    .din   (adc_word),
    .ready (res_ready),
    .valid (res_valid),
    .data  (res_data)
  );

  assign irq = done_flag && irq_en;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int CH_W  = 5,
  parameter int REF_W = 2,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             flag_clr,
  input logic             busy,
  input logic             sh_strobe,
  input logic             done_flag,
  input logic             locked,
  input logic             done_evt,
  input logic [CH_W-1:0]  act_ch,
  input logic [REF_W-1:0] act_ref,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data
);

  p_strobe_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |-> busy);

  p_sel_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({act_ch, act_ref}));

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !done_evt) |=> (res_valid && $stable(res_data)));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !done_evt) |=> !done_flag);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.CH_W(CH_W), .REF_W(REF_W), .RES_W(RES_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .flag_clr  (flag_clr),
  .busy      (busy),
  .sh_strobe (sh_strobe),
  .done_flag (done_flag),
  .locked    (locked),
  .done_evt  (done_evt),
  .act_ch    (act_ch),
  .act_ref   (act_ref),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;

  localparam int CH_W  = 5;
  localparam int REF_W = 2;
  localparam int RES_W = 10;

  typedef struct packed {
    bit         auto_m;
    bit [7:0]   len;
    bit [7:0]   sh;
    bit [9:0]   word;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{auto_m: 1'b0, len: 8'd50, sh: 8'd27, word: 10'h2A5},
    '{auto_m: 1'b0, len: 8'd26, sh: 8'd3,  word: 10'h15A},
    '{auto_m: 1'b0, len: 8'd26, sh: 8'd3,  word: 10'h3FF},
    '{auto_m: 1'b1, len: 8'd27, sh: 8'd4,  word: 10'h001},
    '{auto_m: 1'b1, len: 8'd27, sh: 8'd4,  word: 10'h200}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b1;
  logic en = 1'b0, auto_mode = 1'b0, start_wr = 1'b0, trig = 1'b0;
  logic sel_wr = 1'b0, flag_clr = 1'b0, irq_en = 1'b0, res_ready = 1'b0;
  logic [CH_W-1:0]  sel_ch_in = '0;
  logic [REF_W-1:0] sel_ref_in = '0;
  logic [RES_W-1:0] adc_word = '0;
  logic start_bit, busy, sh_strobe, done_flag, irq, res_valid;
  logic [CH_W-1:0]  act_ch;
  logic [REF_W-1:0] act_ref;
  logic [RES_W-1:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_conv_seq #(.CH_W(CH_W), .REF_W(REF_W), .RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .en(en), .auto_mode(auto_mode),
    .start_wr(start_wr), .trig(trig), .sel_wr(sel_wr), .sel_ch_in(sel_ch_in),
    .sel_ref_in(sel_ref_in), .flag_clr(flag_clr), .irq_en(irq_en), .adc_word(adc_word),
    .res_ready(res_ready), .start_bit(start_bit), .busy(busy), .sh_strobe(sh_strobe),
    .done_flag(done_flag), .irq(irq), .act_ch(act_ch), .act_ref(act_ref),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tidy();
    flag_clr = 1'b1; res_ready = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; res_ready = 1'b0;
  endtask

  task automatic write_sel(input logic [CH_W-1:0] c, input logic [REF_W-1:0] r);
    sel_wr = 1'b1; sel_ch_in = c; sel_ref_in = r;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  // Pulses start or trigger, then records offsets (in negedges) of launch, strobe, completion.
  task automatic run_conv(input bit use_trig, output int db, output int ds,
                          output int dd, output int sh_cnt);
    db = -1; ds = -1; dd = -1; sh_cnt = 0;
    if (use_trig) trig = 1'b1; else start_wr = 1'b1;
    @(negedge clk);
    trig = 1'b0; start_wr = 1'b0;
    for (int k = 1; k < 200; k++) begin
      if (busy && db < 0) db = k;
      if (sh_strobe) begin sh_cnt++; if (ds < 0) ds = k; end
      if (done_flag) begin dd = k; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    wrap_up();
  end

  initial begin
    int db, ds, dd, shc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !start_bit && !done_flag && !irq && !sh_strobe && !res_valid,
          "R1", int'({busy, start_bit, done_flag, irq, sh_strobe, res_valid}), 0);
    check(act_ch == 0 && act_ref == 0, "R1", int'({act_ref, act_ch}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;

    // R2 idle selection follows holding register on the second edge
    write_sel(5'h13, 2'd2);
    check(act_ch == 5'h00, "R2", int'(act_ch), 0);
    @(negedge clk);
    check(act_ch == 5'h13 && act_ref == 2'd2, "R2", int'({act_ref, act_ch}), int'({2'd2, 5'h13}));

    // Vector table: R4 R5 R6 R7 R8 R11 R12
    foreach (VECS[i]) begin
      auto_mode = VECS[i].auto_m;
      adc_word  = VECS[i].word;
      @(negedge clk);
      run_conv(VECS[i].auto_m, db, ds, dd, shc);
      if (VECS[i].auto_m) check(db == 1, "R7", db, 1);
      else check(db == 2 || db == 3, "R4", db, 2);
      check(dd - db == int'(VECS[i].len), VECS[i].len == 50 ? "R5" : "R6_R7", dd - db, int'(VECS[i].len));
      check(ds - db == int'(VECS[i].sh), VECS[i].len == 50 ? "R5" : "R6_R7", ds - db, int'(VECS[i].sh));
      check(shc == 1, "R12", shc, 1);
      check(res_valid && res_data == VECS[i].word, "R11", int'(res_data), int'(VECS[i].word));
      check(start_bit == VECS[i].auto_m, "R8", int'(start_bit), int'(VECS[i].auto_m));
      tidy();
      check(!done_flag && !res_valid, "R9", int'({done_flag, res_valid}), 0);
    end

    // R7 trigger while busy ignored (auto mode still on)
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    db = 1; dd = -1;
    for (int k = 2; k < 200; k++) begin
      @(negedge clk);
      trig = (k == 10);
      if (done_flag) begin dd = k; break; end
    end
    trig = 1'b0;
    check(dd - db == 27, "R7", dd - db, 27);
    check(start_bit == 1'b1, "R8", int'(start_bit), 1);
    tidy();

    // R10 abort, then next conversion is a first one
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!busy && !start_bit, "R10", int'({busy, start_bit}), 0);
    en = 1'b1; auto_mode = 1'b0;
    tidy();
    run_conv(1'b0, db, ds, dd, shc);
    check(dd - db == 50 && ds - db == 27, "R10", dd - db, 50);
    tidy();

    // R3 lock: normal conversion, holding register rewritten just after launch
    write_sel(5'h05, 2'd1);
    @(negedge clk);
    adc_word = 10'h0AB;
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    while (!busy) @(negedge clk);
    write_sel(5'h1C, 2'd3);
    for (int off = 1; off <= 26; off++) begin
      if (off == 1 || off == 24)
        check(act_ch == 5'h05 && act_ref == 2'd1, "R3", int'({act_ref, act_ch}), int'({2'd1, 5'h05}));
      if (off == 25) begin
        check(act_ch == 5'h1C && act_ref == 2'd3, "R3", int'({act_ref, act_ch}), int'({2'd3, 5'h1C}));
        check(!done_flag, "R3", int'(done_flag), 0);
      end
      if (off == 26) check(done_flag, "R3", int'(done_flag), 1);
      if (off < 26) @(negedge clk);
    end

    // R9 irq gating and stickiness
    check(!irq, "R9", int'(irq), 0);
    irq_en = 1'b1;
    #1;
    check(irq, "R9", int'(irq), 1);
    repeat (4) @(negedge clk);
    check(done_flag && irq, "R9", int'({done_flag, irq}), 3);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(!done_flag && !irq, "R9", int'({done_flag, irq}), 0);

    // R11 back-pressure hold, then overwrite by a newer completion
    repeat (3) @(negedge clk);
    check(res_valid && res_data == 10'h0AB, "R11", int'(res_data), 'h0AB);
    adc_word = 10'h155;
    run_conv(1'b0, db, ds, dd, shc);
    check(res_valid && res_data == 10'h155, "R11", int'(res_data), 'h155);
    tidy();
    check(!res_valid, "R11", int'(res_valid), 0);

    wrap_up();
  end

endmodule